// File: doc/BRIEF.md
# Sixteen-Input Interrupt Collector with Fixed Output Routing

This block gathers up to sixteen external interrupt requests and presents them to a processor as four active-high interrupt lines. Each input is first passed through a two-flop synchroniser. Inputs 1 to 14 are active-low level requests. Input 15 is a push-button style source that latches on a falling edge. Input 0 has no request source.

Every captured request sets a bit in a pending-flag register. A mask register gates which flags may reach the outputs, and a 1 in the mask blocks that input. Each of the four outputs is the OR of the unmasked pending flags that belong to its own fixed, irregular group of inputs.

Software reaches both registers over a small 16-bit register bus. Reads return data in the same cycle as the strobe. A pending flag is cleared by writing a 0 to its bit.

Top module: `lvlirq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFFFF, the flag register reads 0x0000 and all four interrupt outputs are 0.
- R2: A write to byte offset 0x4 loads all 16 bits of the mask register. A read at 0x4 returns it. A mask bit of 1 blocks that input from every output, and a mask bit of 0 lets it through.
- R3: A write to byte offset 0xC clears each pending flag whose data bit is 0. It leaves each flag whose data bit is 1 unchanged. A read at 0xC returns the flag register.
- R4: Inputs 1 to 14 are active-low level requests. A low input sets its flag on the third rising clock edge after the input changes, and the output it feeds rises on the fourth. The flag stays set after the input is released, until software clears it.
- R5: While a level input is still held low, writing 0 to its flag has no effect. The new request wins over the clear in the same cycle. The flag clears only once the input has been released.
- R6: Input 15 sets its flag only on a high-to-low transition. Holding it low after the flag is cleared does not set the flag again, and a low-to-high transition sets nothing.
- R7: Flag bit 0 always reads 0, whatever input 0 does.
- R8: Output k is 1 when flag & ~mask & route_k is nonzero, one cycle after the flag register changes. The route masks are 0x0028 for output 0, 0x0050 for output 1, 0x1C00 for output 2 and 0x6386 for output 3. When every mask bit is 1, all outputs are 0.
- R9: Masking an input does not stop its flag from latching. When the mask bit is later cleared, the output for that input asserts.
- R10: A read at any offset other than 0x4 or 0xC returns 0. A write there changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, valid in the cycle of the read strobe, 0 otherwise |
| reqN | input | 16 | External requests, active low (bit 0 unused) |
| irqOut | output | 4 | Routed interrupt lines to the processor, active high |

## Verification
A wrong flag bit shows at the flag register on the next read. It also shows on the interrupt line of its group one clock after it goes wrong, provided that input is unmasked. A fault in the synchroniser or in the edge detector shifts the latency of the flag away from exactly three clock edges, or makes a held button set its flag again after a clear. A wrong route constant makes an input assert the wrong output or none. Sweeping each input alone with the mask open exposes that at once.

// File: rtl/lvlirq_pkg.sv
package lvlirq_pkg;
  typedef struct packed {
    logic wrMask;
    logic wrFlag;
    logic rdMask;
    logic rdFlag;
  } regStrobe_t;
endpackage

// File: rtl/lvlirq_ctrl_unit.sv
module lvlirq_ctrl_unit
  import lvlirq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] MASK_OFS = 4'h4,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 4'hC
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  logic hitMask, hitFlag;

  always_comb begin
    hitMask       = (busAddr == MASK_OFS);
    hitFlag       = (busAddr == FLAG_OFS);
    strobe.wrMask = busWrEn & hitMask;
    strobe.wrFlag = busWrEn & hitFlag;
    strobe.rdMask = busRdEn & hitMask;
    strobe.rdFlag = busRdEn & hitFlag;
  end
endmodule

// File: rtl/lvlirq_datapath.sv
module lvlirq_datapath
  import lvlirq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] LEVEL_SEL = 16'h7FFE,
  parameter logic [DATA_W-1:0] EDGE_SEL  = 16'h8000,
  parameter logic [N_OUT*DATA_W-1:0] ROUTE = {16'h6386, 16'h1C00, 16'h0050, 16'h0028}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] reqN,
  output logic [DATA_W-1:0] rdData,
  output logic [N_OUT-1:0]  irqOut
);
  localparam logic [DATA_W-1:0] LIVE_BITS = LEVEL_SEL | EDGE_SEL;

  logic [DATA_W-1:0] syncQ [SYNC_STAGES];
  logic [DATA_W-1:0] reqLow, prevLow, fallEvt, evtVec, keepVec, flagNext;
  logic [DATA_W-1:0] flagQ, maskQ, liveVec;

  // input synchroniser chain, idle state is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '1;
      prevLow <= '0;
    end else begin
      syncQ[0] <= reqN;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevLow <= reqLow;
    end
  end

  always_comb begin
    reqLow   = ~syncQ[SYNC_STAGES-1];
    fallEvt  = reqLow & ~prevLow & EDGE_SEL;
    evtVec   = (reqLow & LEVEL_SEL) | fallEvt;
    keepVec  = strobe.wrFlag ? wrData : '1;
    flagNext = ((flagQ & keepVec) | evtVec) & LIVE_BITS;
    liveVec  = flagQ & ~maskQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagQ <= '0;
      maskQ <= '1;
    end else begin
      flagQ <= flagNext;
      if (strobe.wrMask) maskQ <= wrData;
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irqOut[k] <= 1'b0;
      else        irqOut[k] <= |(liveVec & ROUTE[k*DATA_W +: DATA_W]);
    end
  end

  always_comb begin
    if (strobe.rdMask)      rdData = maskQ;
    else if (strobe.rdFlag) rdData = flagQ;
    else                    rdData = '0;
  end

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrMask |=> maskQ == $past(wrData));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrFlag |=> ((flagQ & ~$past(wrData) & ~$past(evtVec)) == '0));

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flagQ & ~$past(flagQ) & ~$past(evtVec)) == '0));

  // R6
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fallEvt != '0) |=> ((flagQ & $past(fallEvt)) == $past(fallEvt)));

  // R8
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&maskQ) |=> (irqOut == '0));
endmodule

// File: rtl/lvlirq_ctrl.sv
module lvlirq_ctrl
  import lvlirq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int N_OUT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] reqN,
  output logic [N_OUT-1:0]  irqOut
);
  regStrobe_t strobe;

  lvlirq_ctrl_unit #(.ADDR_W(ADDR_W)) ctrl_i (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  lvlirq_datapath #(.DATA_W(DATA_W), .N_OUT(N_OUT)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .wrData (busWrData),
    .reqN   (reqN),
    .rdData (busRdData),
    .irqOut (irqOut)
  );
endmodule

// File: tb/lvlirq_ctrl_tb_top.sv
module lvlirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [15:0] reqN = '1;
  logic [3:0]  irqOut;
  logic        chkIrq = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit isIrq; logic [15:0] exp; string tag; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  lvlirq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .reqN(reqN), .irqOut(irqOut));

  localparam logic [3:0] A_MASK = 4'h4, A_FLAG = 4'hC;

  function automatic logic [3:0] routeOf(int i);
    logic [15:0] r0 = 16'h0028, r1 = 16'h0050, r2 = 16'h1C00, r3 = 16'h6386;
    return {r3[i], r2[i], r1[i], r0[i]};
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic waitN(int n);
    repeat (n) cyc();
  endtask

  task automatic busRead(logic [3:0] a, logic [15:0] e, string tag);
    q.push_back('{1'b0, e, tag});
    busAddr = a; busRdEn = 1'b1;
    cyc();
    busRdEn = 1'b0;
  endtask

  task automatic busWrite(logic [3:0] a, logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    cyc();
    busWrEn = 1'b0;
  endtask

  task automatic expIrq(logic [3:0] e, string tag);
    q.push_back('{1'b1, {12'b0, e}, tag});
    chkIrq = 1'b1;
    cyc();
    chkIrq = 1'b0;
  endtask

  // monitor: pops expectations and compares mid-cycle
  always @(negedge clk) begin
    if (busRdEn || chkIrq) begin
      item_t it;
      logic [15:0] act;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty act=%h exp=none", busRdData);
      end else begin
        it = q.pop_front();
        act = it.isIrq ? {12'b0, irqOut} : busRdData;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitN(2); rst_n = 1'b1; cyc();
    // R1 reset state
    busRead(A_MASK, 16'hFFFF, "R1 mask reset");
    busRead(A_FLAG, 16'h0000, "R1 flag reset");
    expIrq(4'h0, "R1 irq reset");
    // R2 mask load and readback
    busWrite(A_MASK, 16'h7FFE);
    busRead(A_MASK, 16'h7FFE, "R2 mask readback");
    busWrite(A_MASK, 16'hFFF7);
    busRead(A_MASK, 16'hFFF7, "R2 mask readback 2");
    // R4/R8 exact latency on input 3 (route 0)
    reqN[3] = 1'b0;
    busRead(A_FLAG, 16'h0000, "R4 flag after edge 0");
    busRead(A_FLAG, 16'h0000, "R4 flag after edge 1");
    busRead(A_FLAG, 16'h0000, "R4 flag after edge 2");
    expIrq(4'h0, "R8 irq before flag registered");
    expIrq(4'h1, "R8 irq one cycle after flag");
    busRead(A_FLAG, 16'h0008, "R4 flag set");
    reqN[3] = 1'b1; waitN(5);
    busRead(A_FLAG, 16'h0008, "R4 flag held after release");
    // R3 clear by zero
    busWrite(A_FLAG, 16'hFFF7);
    busRead(A_FLAG, 16'h0000, "R3 flag cleared");
    expIrq(4'h0, "R3 irq drops after clear");
    // R3 ones keep
    reqN[4] = 1'b0; reqN[10] = 1'b0; waitN(3);
    reqN[4] = 1'b1; reqN[10] = 1'b1; waitN(4);
    busRead(A_FLAG, 16'h0410, "R3 two flags set");
    busWrite(A_FLAG, 16'hFBFF);
    busRead(A_FLAG, 16'h0010, "R3 written ones keep flag");
    // R5 held level wins over clear
    reqN[5] = 1'b0; waitN(5);
    busWrite(A_FLAG, 16'h0000);
    busRead(A_FLAG, 16'h0020, "R5 held level survives clear");
    reqN[5] = 1'b1; waitN(5);
    busWrite(A_FLAG, 16'h0000);
    busRead(A_FLAG, 16'h0000, "R5 clears after release");
    // R7 bit 0
    reqN[0] = 1'b0; waitN(5);
    busRead(A_FLAG, 16'h0000, "R7 bit0 stays zero");
    reqN[0] = 1'b1;
    // R6 edge input
    reqN[15] = 1'b0; waitN(5);
    busRead(A_FLAG, 16'h8000, "R6 falling edge latches");
    busWrite(A_FLAG, 16'h0000); waitN(5);
    busRead(A_FLAG, 16'h0000, "R6 held low no relatch");
    reqN[15] = 1'b1; waitN(5);
    busRead(A_FLAG, 16'h0000, "R6 rising edge ignored");
    // R9 masked flag latches, then unmask
    busWrite(A_MASK, 16'hFFFF);
    reqN[6] = 1'b0; waitN(3); reqN[6] = 1'b1; waitN(4);
    busRead(A_FLAG, 16'h0040, "R9 masked flag latched");
    expIrq(4'h0, "R8 all masked gives no irq");
    busWrite(A_MASK, 16'hFFBF); cyc();
    expIrq(4'h2, "R9 unmask asserts output 1");
    busWrite(A_FLAG, 16'h0000);
    // R8 route sweep
    busWrite(A_MASK, 16'h0000);
    for (int i = 1; i < 15; i++) begin
      reqN[i] = 1'b0; waitN(3); reqN[i] = 1'b1; waitN(4);
      expIrq(routeOf(i), $sformatf("R8 route of input %0d", i));
      busWrite(A_FLAG, 16'h0000); waitN(5);
    end
    // R10 unmapped offset
    busWrite(4'h8, 16'h1234);
    busRead(4'h8, 16'h0000, "R10 unmapped read zero");
    busRead(A_MASK, 16'h0000, "R10 unmapped write ignored");
    waitN(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule